// File: doc/BRIEF.md
# Ring Oscillator Neighbour Anomaly Detector

This block watches a 4x4 grid of on-die ring oscillators and reports any site whose oscillation rate disagrees with the sites around it. Oscillators placed close together on the die should run at nearly the same rate, because process variation changes slowly across the die. A site that runs well apart from its surroundings therefore points to local damage, added path delay or tampering. A slowdown of around ten percent after heavy aging stress is a typical example.

Software sets a window exponent and a tolerance and then pulses `start_i`. Every oscillator's rising edges are counted for 2^N system clock cycles. Each site's count is then compared with the average count of its orthogonal neighbours. Corner sites have two neighbours, border sites have three and interior sites have four. A site is flagged when the absolute gap is larger than the tolerance. The result is a 16-bit exclusion mask, and later logic can use it to leave the flagged oscillators out.

The average is never divided out. The test `|k*count - sum| > k*thr`, where k is the neighbour count, gives exactly the same answer without a divide by three.

Top module: `ro_grid_sentinel`

## Requirements
- R1: While reset is held and right after it, `busy_o`, `done_o` and `mask_o` are all zero.
- R2: A start accepted at clock edge E0 opens a counting window of exactly 2^N cycles, with N taken from `win_log2_i`. `done_o` is then high for exactly one cycle, visible just after edge E0 + 2^N + 1.
- R3: A window exponent above 12 is treated as 12, so the pass lasts 4097 edges.
- R4: Site index is row*4 + column, with row 0 first. Bit i of `mask_o` is set when the absolute difference between site i's count and the mean count of its existing up, down, left and right neighbours exceeds the threshold.
- R5: The comparison is strict. Sites whose difference equals the threshold are not flagged, so a uniform grid with threshold 0 gives an all-zero mask.
- R6: Sites that run faster than their neighbours are flagged, as well as sites that run slower.
- R7: A threshold above every site's difference gives an all-zero mask.
- R8: `mask_o` changes only in the cycle in which `done_o` is high. Between passes it holds its value, whatever the oscillators do.
- R9: A start that arrives during a pass is ignored. Threshold and window exponent are captured when a start is accepted, and later changes to them do not affect the running pass.
- R10: `busy_o` is high from the edge that accepts a start until the edge that raises `done_o`, where it falls.
- R11: Oscillator inputs pass through a two-flop synchroniser, and only synchronised rising edges inside the window are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_i | input | 16 | Raw ring oscillator outputs, one per site |
| start_i | input | 1 | Begins a measurement pass when idle |
| win_log2_i | input | 4 | Window exponent N; the window is 2^N cycles |
| thresh_i | input | 16 | Allowed count difference from the neighbour mean |
| busy_o | output | 1 | A pass is running |
| done_o | output | 1 | One-cycle pulse when a new mask is valid |
| mask_o | output | 16 | Exclusion mask, one bit per site |

## Verification
The first pattern drives every site from one shared toggle, which gives identical counts. With a threshold of zero this separates a strict compare from a non-strict one, and it is also used to time the done pulse at two window lengths and at a clamped exponent. The next patterns place a single odd oscillator in three positions: a slow interior site, a slow border site and a fast corner site. Each exercises a different neighbour count and the absolute-value path, and each checks that the neighbours pulled by the odd site are not flagged with it. The remaining patterns raise the threshold to silence all flags, alter the oscillators between passes to show that the mask holds, and send a second start during a pass with a changed threshold to show that it is ignored.

// File: rtl/ro_grid_pkg.sv
`timescale 1ns/1ps
package ro_grid_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_JUDGE = 2'd2
  } pass_state_e;

  // Number of orthogonal neighbours that exist for a grid position.
  function automatic int nbr_degree(int r, int c, int rows, int cols);
    int k;
    k = 0;
    if (r > 0)        k++;
    if (r < rows - 1) k++;
    if (c > 0)        k++;
    if (c < cols - 1) k++;
    return k;
  endfunction

endpackage

// File: rtl/ro_edge_counter.sv
`timescale 1ns/1ps
module ro_edge_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_i,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [2:0]       sync_q, sync_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rise;

  // Two flops resolve metastability; the third remembers the last level.
  assign rise = sync_q[1] & ~sync_q[2];

  always_comb begin
    sync_d = {sync_q[1:0], osc_i};
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i && rise) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/ro_pass_ctrl.sv
`timescale 1ns/1ps
module ro_pass_ctrl
  import ro_grid_pkg::*;
#(
  parameter  int CNT_W    = 16,
  parameter  int MAX_LOG2 = 12,
  localparam int LOG_W    = $clog2(MAX_LOG2 + 1),
  localparam int WIN_W    = (MAX_LOG2 < 1) ? 1 : MAX_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LOG_W-1:0] win_log2_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             clr_o,
  output logic             count_en_o,
  output logic             judge_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] thr_o
);

  pass_state_e      state_q, state_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [LOG_W-1:0] n_q, n_d;
  logic [CNT_W-1:0] thr_q, thr_d;
  logic [LOG_W-1:0] n_clamped;
  logic [WIN_W-1:0] win_last;
  logic             accept;

  assign n_clamped = (win_log2_i > LOG_W'(MAX_LOG2)) ? LOG_W'(MAX_LOG2) : win_log2_i;
  // 2^N - 1; for N equal to the counter width the shift wraps to all ones.
  assign win_last  = (WIN_W'(1) << n_q) - WIN_W'(1);
  assign accept    = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    win_d   = win_q;
    n_d     = n_q;
    thr_d   = thr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_COUNT;
          win_d   = '0;
          n_d     = n_clamped;
          thr_d   = thresh_i;
        end
      end
      ST_COUNT: begin
        win_d = win_q + WIN_W'(1);
        if (win_q == win_last) begin
          state_d = ST_JUDGE;
        end
      end
      ST_JUDGE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      n_q     <= '0;
      thr_q   <= '0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
      n_q     <= n_d;
      thr_q   <= thr_d;
    end
  end

  assign clr_o      = accept;
  assign count_en_o = (state_q == ST_COUNT);
  assign judge_o    = (state_q == ST_JUDGE);
  assign busy_o     = (state_q != ST_IDLE);
  assign thr_o      = thr_q;

endmodule

// File: rtl/ro_nbr_judge.sv
`timescale 1ns/1ps
module ro_nbr_judge
  import ro_grid_pkg::*;
#(
  parameter  int ROWS  = 4,
  parameter  int COLS  = 4,
  parameter  int CNT_W = 16,
  localparam int SITES = ROWS * COLS,
  localparam int EXT_W = CNT_W + 3
) (
  input  logic [SITES-1:0][CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0]            thr_i,
  output logic [SITES-1:0]            flag_o
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      localparam int DEG = nbr_degree(r, c, ROWS, COLS);

      logic [EXT_W-1:0] t_up, t_dn, t_lf, t_rt;
      logic [EXT_W-1:0] nsum, own_k, thr_k, gap;

      if (r > 0) begin : g_up
        assign t_up = EXT_W'(cnt_i[IDX-COLS]);
      end else begin : g_no_up
        assign t_up = '0;
      end
      if (r < ROWS - 1) begin : g_dn
        assign t_dn = EXT_W'(cnt_i[IDX+COLS]);
      end else begin : g_no_dn
        assign t_dn = '0;
      end
      if (c > 0) begin : g_lf
        assign t_lf = EXT_W'(cnt_i[IDX-1]);
      end else begin : g_no_lf
        assign t_lf = '0;
      end
      if (c < COLS - 1) begin : g_rt
        assign t_rt = EXT_W'(cnt_i[IDX+1]);
      end else begin : g_no_rt
        assign t_rt = '0;
      end

      // Scale own count and tolerance by the degree instead of dividing the sum.
      assign nsum  = t_up + t_dn + t_lf + t_rt;
      assign own_k = EXT_W'(cnt_i[IDX]) * EXT_W'(DEG);
      assign thr_k = EXT_W'(thr_i) * EXT_W'(DEG);
      assign gap   = (own_k >= nsum) ? (own_k - nsum) : (nsum - own_k);
      assign flag_o[IDX] = (gap > thr_k);
    end
  end

endmodule

// File: rtl/ro_grid_sentinel.sv
`timescale 1ns/1ps
module ro_grid_sentinel #(
  parameter  int ROWS     = 4,
  parameter  int COLS     = 4,
  parameter  int CNT_W    = 16,
  parameter  int MAX_LOG2 = 12,
  localparam int SITES    = ROWS * COLS,
  localparam int LOG_W    = $clog2(MAX_LOG2 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SITES-1:0] osc_i,
  input  logic             start_i,
  input  logic [LOG_W-1:0] win_log2_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [SITES-1:0] mask_o
);

  logic                        clr, count_en, judge;
  logic [CNT_W-1:0]            thr;
  logic [SITES-1:0][CNT_W-1:0] counts;
  logic [SITES-1:0]            flags;
  logic [SITES-1:0]            mask_q, mask_d;
  logic                        done_q, done_d;

  ro_pass_ctrl #(
    .CNT_W    (CNT_W),
    .MAX_LOG2 (MAX_LOG2)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .win_log2_i (win_log2_i),
    .thresh_i   (thresh_i),
    .clr_o      (clr),
    .count_en_o (count_en),
    .judge_o    (judge),
    .busy_o     (busy_o),
    .thr_o      (thr)
  );

  for (genvar s = 0; s < SITES; s++) begin : g_site
    ro_edge_counter #(
      .CNT_W (CNT_W)
    ) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .osc_i (osc_i[s]),
      .clr_i (clr),
      .en_i  (count_en),
      .cnt_o (counts[s])
    );
  end

  ro_nbr_judge #(
    .ROWS  (ROWS),
    .COLS  (COLS),
    .CNT_W (CNT_W)
  ) i_judge (
    .cnt_i  (counts),
    .thr_i  (thr),
    .flag_o (flags)
  );

  always_comb begin
    mask_d = mask_q;
    done_d = judge;
    if (judge) begin
      mask_d = flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      done_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      done_q <= done_d;
    end
  end

  assign mask_o = mask_q;
  assign done_o = done_q;

endmodule

// File: rtl/ro_grid_sentinel_chk.sv
`timescale 1ns/1ps
module ro_grid_sentinel_chk #(
  parameter int SITES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [SITES-1:0] mask_o
);

  // R2: the completion pulse lasts a single cycle.
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: done marks the end of a busy interval.
  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R10: an idle start makes the block busy on the next edge.
  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R8: the mask moves only together with done.
  a_r8_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(mask_o));

  // R9: a start during a pass does not restart or abort it.
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> (busy_o || done_o));

endmodule

bind ro_grid_sentinel ro_grid_sentinel_chk #(.SITES(SITES)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .mask_o  (mask_o)
);

// File: tb/test_ro_grid_sentinel.sv
`timescale 1ns/1ps
module test_ro_grid_sentinel;

  localparam int SITES = 16;
  localparam int NORM  = 20;  // half period ns: 8 clock cycles per oscillation
  localparam int SLOW  = 24;  // about 17 percent slower
  localparam int FAST  = 16;  // 25 percent faster

  logic        clk;
  logic        rst_n;
  logic [15:0] osc;
  logic        start;
  logic [3:0]  win_log2;
  logic [15:0] thresh;
  logic        busy, done;
  logic [15:0] mask;

  logic [15:0] osc_ind;
  logic        osc_common;
  logic        use_common;
  int          half [SITES];

  int checks;
  int errors;

  assign osc = use_common ? {16{osc_common}} : osc_ind;

  ro_grid_sentinel i_ro_grid_sentinel (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_i      (osc),
    .start_i    (start),
    .win_log2_i (win_log2),
    .thresh_i   (thresh),
    .busy_o     (busy),
    .done_o     (done),
    .mask_o     (mask)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  initial begin
    osc_common = 1'b0;
    forever #(NORM) osc_common = ~osc_common;
  end

  for (genvar g = 0; g < SITES; g++) begin : g_osc
    initial begin
      osc_ind[g] = 1'b0;
      forever begin
        if (half[g] == 0) #5;
        else begin
          #(half[g]);
          osc_ind[g] = ~osc_ind[g];
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic all_normal();
    for (int i = 0; i < SITES; i++) half[i] = NORM;
  endtask

  // Starts a pass, optionally pokes a second start mid-pass, returns edges to done.
  task automatic run_pass(input int n, input int thr, input int poke_at, output int edges);
    int k;
    @(negedge clk);
    start = 1'b1; win_log2 = 4'(n); thresh = 16'(thr);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 busy after accept", busy, 1);
    k = 0;
    do begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (poke_at != 0 && k == poke_at) begin
        start = 1'b1; win_log2 = 4'd4; thresh = 16'd0;
      end else begin
        start = 1'b0;
      end
    end while (!done && k < 70000);
    edges = k;
    check(busy == 1'b0, "R10 busy low at done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R2 done single cycle", done, 0);
  endtask

  task automatic t_reset();
    check(busy == 0 && done == 0 && mask == 0, "R1 reset state", {busy, done, mask}, 0);
  endtask

  task automatic t_uniform_strict();
    int e;
    use_common = 1'b1;
    run_pass(4, 0, 0, e);
    check(e == 17, "R2 window N=4 timing", e, 17);
    check(mask == 16'h0000, "R5 equal counts not flagged at thr 0", mask, 0);
    run_pass(10, 0, 0, e);
    check(e == 1025, "R2 window N=10 timing", e, 1025);
    check(mask == 16'h0000, "R5 R11 uniform grid long window", mask, 0);
    run_pass(15, 0, 0, e);
    check(e == 4097, "R3 exponent clamp", e, 4097);
    use_common = 1'b0;
  endtask

  task automatic t_slow_interior();
    int e;
    all_normal(); half[5] = SLOW;
    run_pass(10, 16, 0, e);
    // interior site 5 gap ~21 over thr 16; neighbours stay under it
    check(mask == 16'h0020, "R4 slow interior site", mask, 16'h0020);
  endtask

  task automatic t_slow_edge();
    int e;
    all_normal(); half[2] = SLOW;
    run_pass(10, 16, 0, e);
    check(mask == 16'h0004, "R4 slow border site", mask, 16'h0004);
  endtask

  task automatic t_fast_corner();
    int e;
    all_normal(); half[0] = FAST;
    run_pass(10, 16, 0, e);
    check(mask == 16'h0001, "R6 fast corner site", mask, 16'h0001);
  endtask

  task automatic t_high_thr();
    int e;
    all_normal(); half[5] = SLOW;
    run_pass(10, 200, 0, e);
    check(mask == 16'h0000, "R7 large threshold", mask, 0);
  endtask

  task automatic t_hold();
    int e;
    all_normal(); half[5] = SLOW;
    run_pass(10, 16, 0, e);
    all_normal(); half[9] = FAST; half[3] = SLOW;
    repeat (400) @(negedge clk);
    check(mask == 16'h0020, "R8 mask held between passes", mask, 16'h0020);
  endtask

  task automatic t_busy_start();
    int e;
    all_normal(); half[5] = SLOW;
    run_pass(10, 16, 100, e);
    check(e == 1025, "R9 mid-pass start ignored", e, 1025);
    check(mask == 16'h0020, "R9 captured threshold kept", mask, 16'h0020);
  endtask

  initial begin
    checks = 0; errors = 0;
    use_common = 1'b0;
    all_normal();
    start = 1'b0; win_log2 = '0; thresh = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_uniform_strict();
    t_slow_interior();
    t_slow_edge();
    t_fast_corner();
    t_high_thr();
    t_hold();
    t_busy_start();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule